// File: doc/BRIEF.md
# Branch, Call and Return Unit

This block decides where a small 16-bit processor core goes next. Each clock cycle it receives one instruction word, the address of that instruction, an operand that has already been resolved from the register file, the four status flags (carry, zero, equal, sign) and the current values of two loop counters. From these it computes the next instruction address as a combinational result. In the same cycle it reports whether a loop counter is to be written back, with its new value. It also reports whether the interrupt in-service flag is to be cleared, and whether the word is an illegal stack combination.

The block holds the hardware return stack itself: 8 entries of 16 bits and a 3-bit stack pointer that wraps. Calls and pushes pre-increment the pointer and write the new top entry. Returns, pops and any instruction whose source is the stack top read the entry under the pointer and then decrement it. Each instruction takes one cycle. The stack update takes effect at the rising edge that ends that cycle.

Top module: `flow_ctl_unit`

## Requirements
- R1: A word with bits 11:8 = 1100 that is not a return (R5) is a jump. Bits 14:12 select its condition: 000 always, 010 carry set, 110 carry clear, 001 zero set, 101 zero clear, 100 sign set. If the jump is taken and bit 15 is 0, next_ip = ip + the sign-extended bits 7:0. If it is taken and bit 15 is 1, next_ip = src_val.
- R2: The equal-flag conditions (bits 14:12 = 011 for equal set, 111 for equal clear) branch only when bit 15 is 0. A word with bit 15 = 1, bits 11:8 = 1100 and one of those two codes does not branch, and next_ip = ip + 1.
- R3: A word with bits 14:13 = 10 and bits 11:8 = 1101 is a decrement-and-branch. Bit 12 picks the counter (0 → lc0, 1 → lc1). lc_we has exactly that bit set and lc_next = counter − 1, modulo 2^16. The branch is taken only if lc_next is nonzero. At most one bit of lc_we is ever set.
- R4: A word with bits 14:12 = 011 and bits 11:8 = 1101 is a call. It always transfers control, using the target rule of R1. It pushes ip + 1.
- R5: A word with bit 15 = 1, bits 11:8 = 1100 and bits 6:0 = 000_1101 is a return, unless bits 14:12 are 011 or 111. It uses the condition codes of R1. When taken, next_ip = stk_top and the stack pops. When not taken, next_ip = ip + 1 and stk_ptr is unchanged.
- R6: ins_clr is 1 exactly when a pop occurs and bit 7 is set, which covers taken interrupt returns (low byte 0x8D) and pop-interrupt words.
- R7: A push (bits 14:12 = 000, bits 11:8 = 1101) stores the operand at stk_ptr + 1 and increments stk_ptr. The operand is src_val when bit 15 = 1 and the sign-extended bits 7:0 when bit 15 = 0. Any word with bit 15 = 1 and bits 6:0 = 000_1101 pops: stk_ptr decrements. If such a word uses a source operand, that operand is stk_top instead of src_val.
- R8: A word that both pushes and pops is invalid. So is a popping word whose bits 14:8 are 001_1101, the stack-pointer destination. An invalid word raises bad_instr, leaves the stack and counters untouched, and gives next_ip = ip + 1.
- R9: The stack pointer wraps modulo 8 in both directions.
- R10: After reset stk_ptr = 0 and every stack entry is 0.
- R11: Any other word gives next_ip = ip + 1 and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word being executed |
| ip | input | 16 | Address of the current instruction |
| src_val | input | 16 | Resolved register operand |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_e | input | 1 | Equal flag |
| flag_s | input | 1 | Sign flag |
| lc0 | input | 16 | Loop counter 0 |
| lc1 | input | 16 | Loop counter 1 |
| next_ip | output | 16 | Address of the next instruction |
| lc_we | output | 2 | Write strobe per loop counter |
| lc_next | output | 16 | Decremented value of the selected counter |
| ins_clr | output | 1 | Clear the interrupt in-service flag |
| bad_instr | output | 1 | Invalid stack combination |
| stk_ptr | output | log2(DEPTH) (3) | Return stack pointer |
| stk_top | output | 16 | Stack entry under the pointer |

## Verification
The outputs next_ip, lc_we, lc_next, ins_clr and bad_instr are combinational and are due in the same cycle as the instruction word. The bench drives each word on a falling edge and samples these outputs 1 ns later. Stack effects land on the following rising edge. The bench therefore compares stk_ptr and stk_top against its own stack model at the start of the next step, after that edge and before the next word is driven.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int DW = 16;
  localparam logic [3:0] GRP_FLOW = 4'b1100;
  localparam logic [3:0] GRP_STK  = 4'b1101;
  localparam logic [6:0] SP_DST   = 7'b001_1101;

  typedef struct packed {
    logic       popraw;
    logic       pushes;
    logic       is_jump;
    logic       is_ret;
    logic       is_djnz;
    logic       is_call;
    logic       bad;
    logic       cond;
    logic       lc_sel;
    logic       absolute;
    logic       int_ret;
    logic [7:0] imm;
  } dec_t;

  function automatic logic cond_met(input logic [2:0] cc, input logic c, z, e, s);
    case (cc)
      3'b000:  return 1'b1;
      3'b010:  return c;
      3'b110:  return ~c;
      3'b001:  return z;
      3'b101:  return ~z;
      3'b100:  return s;
      3'b011:  return e;
      default: return ~e;
    endcase
  endfunction

  function automatic logic [DW-1:0] sext8(input logic [7:0] b);
    return {{(DW-8){b[7]}}, b};
  endfunction

  function automatic logic [DW-1:0] step_ip(input logic [DW-1:0] a);
    return a + DW'(1);
  endfunction
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
(
  input  logic [DW-1:0] instr,
  input  logic          fc,
  input  logic          fz,
  input  logic          fe,
  input  logic          fs,
  output dec_t          dec
);
  logic       f;
  logic [2:0] cc;
  logic [3:0] grp;
  logic [7:0] lo;
  logic       e_code;

  always_comb begin
    f      = instr[15];
    cc     = instr[14:12];
    grp    = instr[11:8];
    lo     = instr[7:0];
    e_code = (cc[1:0] == 2'b11);

    dec.popraw   = f && (lo[6:0] == 7'h0D);
    dec.is_ret   = dec.popraw && (grp == GRP_FLOW) && !e_code;
    dec.is_jump  = (grp == GRP_FLOW) && !dec.is_ret && !(f && e_code);
    dec.is_djnz  = (grp == GRP_STK) && (cc[2:1] == 2'b10);
    dec.is_call  = (grp == GRP_STK) && (cc == 3'b011);
    dec.pushes   = (grp == GRP_STK) && ((cc == 3'b000) || (cc == 3'b011));
    dec.bad      = dec.popraw && (dec.pushes || (instr[14:8] == SP_DST));
    dec.cond     = cond_met(cc, fc, fz, fe, fs);
    dec.lc_sel   = instr[12];
    dec.absolute = f;
    dec.int_ret  = lo[7];
    dec.imm      = lo;
  end
endmodule

// File: rtl/flow_retstack.sv
module flow_retstack #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int SPW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic [W-1:0]   wdata,
  output logic [SPW-1:0] sp,
  output logic [W-1:0]   top
);
  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp_up;

  assign sp_up = sp + SPW'(1);
  assign top   = mem[sp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp_up] <= wdata;
      sp         <= sp_up;
    end else if (pop) begin
      sp <= sp - SPW'(1);
    end
  end

  assert_push_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp == SPW'($past(sp) + SPW'(1)));
  assert_push_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top == $past(wdata));
  assert_pop_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp == SPW'($past(sp) - SPW'(1)));
  assert_idle_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push) |=> $stable(sp));
endmodule

// File: rtl/flow_nextip.sv
module flow_nextip
  import flow_pkg::*;
(
  input  logic          absolute,
  input  logic          popsrc,
  input  logic [7:0]    imm,
  input  logic          lc_sel,
  input  logic          is_jump,
  input  logic          is_ret,
  input  logic          is_djnz,
  input  logic          is_call,
  input  logic          cond,
  input  logic          bad,
  input  logic [DW-1:0] ip,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] top,
  input  logic [DW-1:0] lc0,
  input  logic [DW-1:0] lc1,
  output logic [DW-1:0] next_ip,
  output logic [DW-1:0] push_data,
  output logic [DW-1:0] lc_next
);
  logic [DW-1:0] operand;
  logic [DW-1:0] target;
  logic          taken;

  always_comb begin
    operand = absolute ? (popsrc ? top : src_val) : sext8(imm);
    target  = absolute ? operand : ip + sext8(imm);
    lc_next = (lc_sel ? lc1 : lc0) - DW'(1);
    taken   = !bad && (((is_jump || is_ret) && cond)
                       || (is_djnz && (lc_next != '0))
                       || is_call);
    if (!taken)      next_ip = step_ip(ip);
    else if (is_ret) next_ip = top;
    else             next_ip = target;
    push_data = is_call ? step_ip(ip) : operand;
  end
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
  import flow_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              instr,
  input  logic [15:0]              ip,
  input  logic [15:0]              src_val,
  input  logic                     flag_c,
  input  logic                     flag_z,
  input  logic                     flag_e,
  input  logic                     flag_s,
  input  logic [15:0]              lc0,
  input  logic [15:0]              lc1,
  output logic [15:0]              next_ip,
  output logic [1:0]               lc_we,
  output logic [15:0]              lc_next,
  output logic                     ins_clr,
  output logic                     bad_instr,
  output logic [$clog2(DEPTH)-1:0] stk_ptr,
  output logic [15:0]              stk_top
);
  dec_t          d;
  logic          push_act;
  logic          pop_act;
  logic [DW-1:0] push_data;

  flow_decode u_dec (
    .instr (instr),
    .fc    (flag_c),
    .fz    (flag_z),
    .fe    (flag_e),
    .fs    (flag_s),
    .dec   (d)
  );

  // Events brought out for the checks below
  assign push_act  = d.pushes & ~d.bad;
  assign pop_act   = d.popraw & ~d.bad & ~(d.is_ret & ~d.cond);
  assign lc_we[0]  = d.is_djnz & ~d.bad & ~d.lc_sel;
  assign lc_we[1]  = d.is_djnz & ~d.bad &  d.lc_sel;
  assign ins_clr   = pop_act & d.int_ret;
  assign bad_instr = d.bad;

  flow_nextip u_nip (
    .absolute  (d.absolute),
    .popsrc    (d.popraw),
    .imm       (d.imm),
    .lc_sel    (d.lc_sel),
    .is_jump   (d.is_jump),
    .is_ret    (d.is_ret),
    .is_djnz   (d.is_djnz),
    .is_call   (d.is_call),
    .cond      (d.cond),
    .bad       (d.bad),
    .ip        (ip),
    .src_val   (src_val),
    .top       (stk_top),
    .lc0       (lc0),
    .lc1       (lc1),
    .next_ip   (next_ip),
    .push_data (push_data),
    .lc_next   (lc_next)
  );

  flow_retstack #(.DEPTH(DEPTH), .W(DW)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_act),
    .pop   (pop_act),
    .wdata (push_data),
    .sp    (stk_ptr),
    .top   (stk_top)
  );

  assert_bad_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_instr |-> (!push_act && !pop_act && lc_we == 2'b00));
  assert_bad_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_instr |=> $stable(stk_ptr));
  assert_insclr_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_clr |-> pop_act);
  assert_ret_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (d.is_ret && !d.cond) |=> $stable(stk_ptr));
  assert_one_counter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lc_we));
endmodule

// File: tb/flow_ctl_unit_bench.sv
module flow_ctl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0, ip = '0, src_val = '0, lc0 = '0, lc1 = '0;
  logic        flag_c = 0, flag_z = 0, flag_e = 0, flag_s = 0;
  logic [15:0] next_ip, lc_next, stk_top;
  logic [1:0]  lc_we;
  logic        ins_clr, bad_instr;
  logic [2:0]  stk_ptr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] m_stk [8];
  logic [2:0]  m_sp;

  always #2 clk = ~clk;

  flow_ctl_unit u_flow_ctl_unit (
    .clk(clk), .rst_n(rst_n), .instr(instr), .ip(ip), .src_val(src_val),
    .flag_c(flag_c), .flag_z(flag_z), .flag_e(flag_e), .flag_s(flag_s),
    .lc0(lc0), .lc1(lc1), .next_ip(next_ip), .lc_we(lc_we), .lc_next(lc_next),
    .ins_clr(ins_clr), .bad_instr(bad_instr), .stk_ptr(stk_ptr), .stk_top(stk_top)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_cond(input bit [2:0] cc, input bit c, z, e, s);
    bit v;
    case (cc[1:0])
      2'b10:   v = c;
      2'b01:   v = z;
      2'b11:   v = e;
      default: v = cc[2] ? s : 1'b1;
    endcase
    if (cc[1:0] != 2'b00 && cc[2]) v = !v;
    return v;
  endfunction

  function automatic logic [15:0] sx(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  task automatic step(input logic [15:0] w, input logic [15:0] ipv, input logic [15:0] sv,
                      input logic [3:0] fl, input logic [15:0] l0, input logic [15:0] l1);
    bit f, popw, ret, jmp, djnz, call, psh, bad, ok, tk, dopop;
    logic [2:0]  cc;
    logic [3:0]  grp;
    logic [7:0]  lo;
    logic [15:0] top, opnd, tgt, exp_ip, cnt, pdata;
    string tag;
    @(negedge clk);
    chk("R7", "stack pointer", {13'b0, stk_ptr}, {13'b0, m_sp});
    chk("R7", "stack top", stk_top, m_stk[m_sp]);
    instr = w; ip = ipv; src_val = sv; lc0 = l0; lc1 = l1;
    {flag_c, flag_z, flag_e, flag_s} = fl;
    #1;
    f = w[15]; cc = w[14:12]; grp = w[11:8]; lo = w[7:0];
    top  = m_stk[m_sp];
    popw = f && (lo == 8'h0D || lo == 8'h8D);
    ret  = popw && grp == 4'hC && !(cc == 3'd3 || cc == 3'd7);
    jmp  = grp == 4'hC && !ret && !(f && (cc == 3'd3 || cc == 3'd7));
    djnz = grp == 4'hD && cc[2:1] == 2'b10;
    call = grp == 4'hD && cc == 3'd3;
    psh  = grp == 4'hD && (cc == 3'd0 || cc == 3'd3);
    bad  = popw && (psh || w[14:8] == 7'h1D);
    ok   = exp_cond(cc, fl[3], fl[2], fl[1], fl[0]);
    opnd = f ? (popw ? top : sv) : sx(lo);
    tgt  = f ? opnd : ipv + sx(lo);
    cnt  = (w[12] ? l1 : l0) - 16'd1;
    tk   = !bad && ((jmp && ok) || (ret && ok) || (djnz && cnt != 0) || call);
    exp_ip = !tk ? ipv + 16'd1 : (ret ? top : tgt);
    if (bad) tag = "R8";
    else if (ret) tag = "R5";
    else if (call) tag = "R4";
    else if (djnz) tag = "R3";
    else if (grp == 4'hC && (cc == 3'd3 || cc == 3'd7)) tag = "R2";
    else if (jmp) tag = "R1";
    else tag = "R11";
    chk(tag, "next_ip", next_ip, exp_ip);
    chk("R8", "bad_instr", {15'b0, bad_instr}, {15'b0, bad});
    dopop = popw && !bad && !(ret && !ok);
    chk("R6", "ins_clr", {15'b0, ins_clr}, {15'b0, dopop && lo[7]});
    chk("R3", "lc_we", {14'b0, lc_we},
        {14'b0, (djnz && !bad && w[12]), (djnz && !bad && !w[12])});
    if (djnz && !bad) chk("R3", "lc_next", lc_next, cnt);
    pdata = call ? ipv + 16'd1 : opnd;
    if (psh && !bad) begin
      m_sp = m_sp + 3'd1;
      m_stk[m_sp] = pdata;
    end else if (dopop) begin
      m_sp = m_sp - 3'd1;
    end
  endtask

  function automatic logic [15:0] rnd_word();
    logic [15:0] r = 16'($urandom);
    bit b = r[15];
    case ($urandom % 10)
      0: return {b, r[14:12], 4'hC, r[7:0]};
      1: return {1'b1, r[14:12], 4'hC, r[0] ? 8'h8D : 8'h0D};
      2: return {b, 2'b10, r[12], 4'hD, r[7:0]};
      3: return {b, 3'b011, 4'hD, r[7:0]};
      4, 5: return {b, 3'b000, 4'hD, r[7:0]};
      6: return {1'b1, r[14:8], r[0] ? 8'h8D : 8'h0D};
      7: return {1'b1, 7'h1D, 8'h0D};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_sp = 3'd0;
    for (int i = 0; i < 8; i++) m_stk[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10", "stk_ptr after reset", {13'b0, stk_ptr}, 16'h0);
    chk("R10", "stk_top after reset", stk_top, 16'h0);
    // R7 push immediate, R4 absolute call, R5 return
    step(16'h0D05, 16'h0100, 16'h0000, 4'b0000, 16'h5, 16'h5);
    step(16'hBD20, 16'h0200, 16'h1234, 4'b0000, 16'h5, 16'h5);
    step(16'h8C0D, 16'h1234, 16'h0000, 4'b0000, 16'h5, 16'h5);
    // R5 untaken return on zero
    step(16'h9C0D, 16'h0300, 16'h0000, 4'b0000, 16'h5, 16'h5);
    // R6 interrupt return
    step(16'h8C8D, 16'h0400, 16'h0000, 4'b0000, 16'h5, 16'h5);
    // R8 push+pop and SP move with pop
    step(16'h8D0D, 16'h0500, 16'h7777, 4'b0000, 16'h5, 16'h5);
    step(16'h9D0D, 16'h0600, 16'h7777, 4'b0000, 16'h5, 16'h5);
    step(16'hBD0D, 16'h0680, 16'h7777, 4'b0000, 16'h5, 16'h5);
    // R3 counter to zero, and wrap from zero
    step(16'h4D05, 16'h0700, 16'h0000, 4'b0000, 16'h1, 16'h9);
    step(16'h5DFE, 16'h0800, 16'h0000, 4'b0000, 16'h9, 16'h0);
    // R2 equal-flag jump relative, and absolute form not branching
    step(16'h3C10, 16'h0900, 16'h0000, 4'b0010, 16'h5, 16'h5);
    step(16'hBC10, 16'h0A00, 16'hBEEF, 4'b0010, 16'h5, 16'h5);
    step(16'h7C10, 16'h0B00, 16'h0000, 4'b0000, 16'h5, 16'h5);
    // R1 conditional jumps
    step(16'hAC11, 16'h0C00, 16'h4444, 4'b1000, 16'h5, 16'h5);
    step(16'hEC11, 16'h0C00, 16'h4444, 4'b1000, 16'h5, 16'h5);
    step(16'h4CF0, 16'h0D00, 16'h0000, 4'b0001, 16'h5, 16'h5);
    // R9 wrap: ten pushes, then ten pops
    for (int i = 0; i < 10; i++) step(16'h8D01, 16'(i), 16'(16'hA000 + i), 4'b0, 16'h5, 16'h5);
    for (int i = 0; i < 10; i++) step(16'h8E0D, 16'(i), 16'h0, 4'b0, 16'h5, 16'h5);
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a = 16'($urandom % 4);
      logic [15:0] b = ($urandom % 2) ? 16'($urandom) : 16'($urandom % 3);
      step(rnd_word(), 16'($urandom), 16'($urandom), 4'($urandom), a, b);
    end
    @(negedge clk);
    chk("R7", "final stack pointer", {13'b0, stk_ptr}, {13'b0, m_sp});
    chk("R7", "final stack top", stk_top, m_stk[m_sp]);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule